// File: doc/BRIEF.md
# Per-Net Fault Injection Saboteur

This block sits inside a single net of a design under test, between the cell that drives the net and the cells that read it. In normal operation it passes the original value straight through. When the injection controller enables it, the block can replace that value with a faulty one. The possible faults are a constant low, a constant high, the value from one cycle earlier, a one-cycle inversion, or a floating-net imitation built from pseudorandom bits.

Configuration reaches the block serially. A 6-bit shift stage is chained through every saboteur on the chip. A separate 6-bit active pattern register copies the shift stage only when the update strobe is asserted, so a new pattern can be shifted in while the old one is still being applied. The active pattern holds two 3-bit fault codes, one for each injection phase. The controller's phase-select input chooses which of the two codes is in force.

A build parameter can reduce the output selector to a single fault model. The stuck-open model ANDs together the pseudorandom bits picked by a build-time mask.

Top module: `net_saboteur`

## Requirements
- R1: While reset is asserted, and after reset, the active pattern is all zero. The net output equals the original input, and the chain output is 0.
- R2: The chain moves one place per cycle while shift is high. The bit that enters at `cfg_data_i` appears at `cfg_data_o` after six shifts, with the first bit shifted in appearing first. While shift is low, the chain holds its contents.
- R3: The active pattern changes only on a cycle with the update strobe high. While new bits are being shifted in, the fault already loaded stays applied.
- R4: When `inj_en_i` is low, `net_fault_o` equals `net_orig_i`, whatever the pattern holds.
- R5: Pattern bits [2:0] hold the code used when `phase_i` is 0, and bits [5:3] hold the code used when `phase_i` is 1. The pattern is shifted in MSB first.
- R6: Code 001 forces the output to 0, and code 010 forces it to 1.
- R7: Code 011 drives the output with the value that `net_orig_i` had in the previous cycle.
- R8: Code 100 inverts the net for one cycle only: the first cycle in which the code is in force. That is the cycle after an update, after a change of `phase_i`, or after `inj_en_i` rises. In all other cycles the net passes through unchanged.
- R9: Code 101 drives the AND of the `lfsr_i` bits selected by `OPEN_MASK`. The default mask is 8'h05, which selects bits 0 and 2.
- R10: Codes 000, 110 and 111 inject no fault.
- R11: When update and shift are both high in the same cycle, the pattern takes the chain contents from before that shift.
- R12: With `MODEL_SEL` set to a nonzero code, only that code injects a fault, and every other code passes the net through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_shift_i | input | 1 | Advance the configuration chain |
| cfg_data_i | input | 1 | Serial bit from the previous unit or the controller |
| cfg_update_i | input | 1 | Copy the chain into the active pattern |
| cfg_data_o | output | 1 | Serial bit to the next unit |
| inj_en_i | input | 1 | Injection enable from the controller |
| phase_i | input | 1 | Selects which half of the pattern is in force |
| lfsr_i | input | LFSR_W | Pseudorandom bits from the shared generator |
| net_orig_i | input | 1 | Value from the original driver |
| net_fault_o | output | 1 | Value delivered to the driven cells |

## Verification
A corrupted chain bit shows up at `cfg_data_o` within six shift cycles, and it shows up as the wrong fault once that bit is loaded. A wrong active pattern or a wrong phase half is visible on `net_fault_o` in the very cycle after the update or the phase change. A stale delay register shows up in the next cycle. A missing or repeated SEU pulse shows up as one cycle too few or too many of inversion. The scenarios drive `net_orig_i` opposite to each fault value so that every mismatch changes the output.

// File: rtl/fiu_pkg.sv
package fiu_pkg;
  localparam int CODE_W   = 3;
  localparam int N_PHASES = 2;

  typedef enum logic [CODE_W-1:0] {
    FM_NONE = 3'd0,
    FM_SA0  = 3'd1,
    FM_SA1  = 3'd2,
    FM_DLY  = 3'd3,
    FM_SEU  = 3'd4,
    FM_OPEN = 3'd5
  } fault_code_e;
endpackage

// File: rtl/fiu_cfg_chain.sv
module fiu_cfg_chain #(
  parameter int PAT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             data_i,
  input  logic             update_i,
  output logic             data_o,
  output logic [PAT_W-1:0] shift_q_o,
  output logic [PAT_W-1:0] pat_q_o,
  output logic             loaded_o
);
  logic [PAT_W-1:0] shift_q, pat_q;
  logic             loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else if (shift_i) shift_q <= {shift_q[PAT_W-2:0], data_i};
  end

  // pattern samples pre-shift chain contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q    <= '0;
      loaded_q <= 1'b0;
    end else begin
      loaded_q <= update_i;
      if (update_i) pat_q <= shift_q;
    end
  end

  assign data_o    = shift_q[PAT_W-1];
  assign shift_q_o = shift_q;
  assign pat_q_o   = pat_q;
  assign loaded_o  = loaded_q;
endmodule

// File: rtl/fiu_fault_src.sv
module fiu_fault_src #(
  parameter int                LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] OPEN_MASK = 8'h05
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              net_i,
  input  logic              phase_i,
  input  logic              en_i,
  input  logic              loaded_i,
  input  logic [LFSR_W-1:0] lfsr_i,
  output logic              dly_o,
  output logic              first_o,
  output logic              open_o
);
  logic dly_q, phase_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q   <= 1'b0;
      phase_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      dly_q   <= net_i;
      phase_q <= phase_i;
      en_q    <= en_i;
    end
  end

  assign dly_o   = dly_q;
  // first cycle of a code being in force
  assign first_o = loaded_i | (phase_i ^ phase_q) | (en_i & ~en_q);
  // unmasked bits read as 1 so they drop out of the AND
  assign open_o  = &(lfsr_i | ~OPEN_MASK);
endmodule

// File: rtl/fiu_fault_mux.sv
module fiu_fault_mux
  import fiu_pkg::*;
#(
  parameter int MODEL_SEL = 0
) (
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              net_i,
  input  logic              dly_i,
  input  logic              first_i,
  input  logic              open_i,
  output logic              net_o
);
  if (MODEL_SEL == 0) begin : g_full
    logic fault_v;
    always_comb begin
      case (code_i)
        FM_SA0:  fault_v = 1'b0;
        FM_SA1:  fault_v = 1'b1;
        FM_DLY:  fault_v = dly_i;
        FM_SEU:  fault_v = net_i ^ first_i;
        FM_OPEN: fault_v = open_i;
        default: fault_v = net_i;
      endcase
    end
    assign net_o = en_i ? fault_v : net_i;
  end else begin : g_single
    logic fault_v;
    if (MODEL_SEL == 1) begin : g_sa0
      assign fault_v = 1'b0;
    end else if (MODEL_SEL == 2) begin : g_sa1
      assign fault_v = 1'b1;
    end else if (MODEL_SEL == 3) begin : g_dly
      assign fault_v = dly_i;
    end else if (MODEL_SEL == 4) begin : g_seu
      assign fault_v = net_i ^ first_i;
    end else begin : g_open
      assign fault_v = open_i;
    end
    assign net_o = (en_i && code_i == CODE_W'(MODEL_SEL)) ? fault_v : net_i;
  end
endmodule

// File: rtl/net_saboteur.sv
module net_saboteur
  import fiu_pkg::*;
#(
  parameter int                LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] OPEN_MASK = 8'h05,
  parameter int                MODEL_SEL = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_shift_i,
  input  logic              cfg_data_i,
  input  logic              cfg_update_i,
  output logic              cfg_data_o,
  input  logic              inj_en_i,
  input  logic              phase_i,
  input  logic [LFSR_W-1:0] lfsr_i,
  input  logic              net_orig_i,
  output logic              net_fault_o
);
  localparam int PAT_W = CODE_W * N_PHASES;

  logic [PAT_W-1:0]  shift_q, pat_q;
  logic              loaded;
  logic              dly, first, open_v;
  logic [CODE_W-1:0] code_arr [N_PHASES];
  logic [CODE_W-1:0] act_code;

  fiu_cfg_chain #(.PAT_W(PAT_W)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (cfg_shift_i),
    .data_i    (cfg_data_i),
    .update_i  (cfg_update_i),
    .data_o    (cfg_data_o),
    .shift_q_o (shift_q),
    .pat_q_o   (pat_q),
    .loaded_o  (loaded)
  );

  for (genvar g = 0; g < N_PHASES; g++) begin : g_phase
    assign code_arr[g] = pat_q[g*CODE_W +: CODE_W];
  end
  assign act_code = code_arr[phase_i];

  fiu_fault_src #(.LFSR_W(LFSR_W), .OPEN_MASK(OPEN_MASK)) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .net_i    (net_orig_i),
    .phase_i  (phase_i),
    .en_i     (inj_en_i),
    .loaded_i (loaded),
    .lfsr_i   (lfsr_i),
    .dly_o    (dly),
    .first_o  (first),
    .open_o   (open_v)
  );

  fiu_fault_mux #(.MODEL_SEL(MODEL_SEL)) u_mux (
    .en_i    (inj_en_i),
    .code_i  (act_code),
    .net_i   (net_orig_i),
    .dly_i   (dly),
    .first_i (first),
    .open_i  (open_v),
    .net_o   (net_fault_o)
  );
endmodule

// File: rtl/net_saboteur_chk.sv
module net_saboteur_chk #(
  parameter int PAT_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_shift_i,
  input logic             cfg_update_i,
  input logic             inj_en_i,
  input logic             net_orig_i,
  input logic             net_fault_o,
  input logic [PAT_W-1:0] shift_q,
  input logic [PAT_W-1:0] pat_q
);
  p_passthru_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_en_i |-> net_fault_o == net_orig_i);

  p_chain_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_shift_i |=> $stable(shift_q));

  p_chain_move_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_shift_i |=> shift_q[PAT_W-1:1] == $past(shift_q[PAT_W-2:0]));

  p_pat_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_update_i |=> $stable(pat_q));

  p_pat_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_update_i |=> pat_q == $past(shift_q));
endmodule

bind net_saboteur net_saboteur_chk #(.PAT_W(PAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_shift_i  (cfg_shift_i),
  .cfg_update_i (cfg_update_i),
  .inj_en_i     (inj_en_i),
  .net_orig_i   (net_orig_i),
  .net_fault_o  (net_fault_o),
  .shift_q      (shift_q),
  .pat_q        (pat_q)
);

// File: tb/tb_net_saboteur.sv
module tb_net_saboteur;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sh = 1'b0, din = 1'b0, upd = 1'b0, en = 1'b0, ph = 1'b0, orig = 1'b1;
  logic [7:0] lf = 8'h00;
  logic       data_o, out, out_sa1;

  int         checks = 0, errors = 0;
  bit         done = 0;
  int         sel_q[$];
  logic       exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  net_saboteur dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_shift_i(sh), .cfg_data_i(din),
    .cfg_update_i(upd), .cfg_data_o(data_o), .inj_en_i(en), .phase_i(ph),
    .lfsr_i(lf), .net_orig_i(orig), .net_fault_o(out)
  );

  logic unused_data;
  net_saboteur #(.MODEL_SEL(2)) dut_sa1 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_shift_i(sh), .cfg_data_i(din),
    .cfg_update_i(upd), .cfg_data_o(unused_data), .inj_en_i(en), .phase_i(ph),
    .lfsr_i(lf), .net_orig_i(orig), .net_fault_o(out_sa1)
  );

  // sel: 0 net_fault_o, 1 cfg_data_o, 2 single-model net output
  task automatic push(input int sel, input logic exp, input string tag);
    sel_q.push_back(sel);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic cyc(input logic s, input logic d, input logic u, input logic e,
                     input logic p, input logic o, input logic [7:0] l,
                     input int sel, input logic exp, input string tag);
    @(negedge clk);
    #1;
    sh = s; din = d; upd = u; en = e; ph = p; orig = o; lf = l;
    if (sel >= 0) push(sel, exp, tag);
  endtask

  task automatic load(input logic [5:0] pat);
    for (int i = 5; i >= 0; i--) cyc(1, pat[i], 0, 1, 0, 0, 8'h00, -1, 0, "");
    cyc(0, 0, 1, 1, 0, 0, 8'h00, -1, 0, "");
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #4;
      while (sel_q.size() > 0) begin
        int    s;
        logic  e, a;
        string t;
        s = sel_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = (s == 0) ? out : (s == 1) ? data_o : out_sa1;
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%b expected=%b", t, s, a, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    // R1 during reset
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 1, "R1 out in reset");
    push(1, 0, "R1 chain out in reset");
    @(negedge clk); rst_ni = 1'b1;
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 1, "R1 out after reset");

    // R2 chain order, R3 no update no load
    cyc(1, 1, 0, 1, 0, 1, 8'h00, -1, 0, "");
    cyc(1, 0, 0, 1, 0, 1, 8'h00, -1, 0, "");
    cyc(1, 1, 0, 1, 0, 1, 8'h00, -1, 0, "");
    cyc(1, 1, 0, 1, 0, 1, 8'h00, -1, 0, "");
    cyc(1, 0, 0, 1, 0, 1, 8'h00, -1, 0, "");
    cyc(1, 0, 0, 1, 0, 1, 8'h00, -1, 0, "");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 1, 1, "R2 first bit out");
    push(0, 1, "R3 chain data not applied");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 1, 1, "R2 hold");
    cyc(1, 0, 0, 1, 0, 1, 8'h00, 1, 1, "R2 bit0");
    cyc(1, 0, 0, 1, 0, 1, 8'h00, 1, 0, "R2 bit1");
    cyc(1, 0, 0, 1, 0, 1, 8'h00, 1, 1, "R2 bit2");
    cyc(1, 0, 0, 1, 0, 1, 8'h00, 1, 1, "R2 bit3");
    cyc(1, 0, 0, 1, 0, 1, 8'h00, 1, 0, "R2 bit4");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 1, 0, "R2 bit5");

    // R5 R6 R12: phase1 SA0, phase0 SA1
    load(6'b001_010);
    cyc(0, 0, 0, 1, 0, 0, 8'h00, 0, 1, "R6 SA1 phase0");
    push(2, 1, "R12 single SA1 injects");
    cyc(0, 0, 0, 1, 1, 1, 8'h00, 0, 0, "R5 SA0 phase1");
    push(2, 1, "R12 single ignores SA0");
    // R4
    cyc(0, 0, 0, 0, 0, 0, 8'h00, 0, 0, "R4 disabled passthru");
    push(2, 0, "R4 disabled single");

    // R3 old fault held while shifting delay pattern 000_011
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 0, 1, "R3 held s0");
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 0, 1, "R3 held s1");
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 0, 1, "R3 held s2");
    cyc(1, 0, 0, 1, 0, 0, 8'h00, 0, 1, "R3 held s3");
    cyc(1, 1, 0, 1, 0, 0, 8'h00, 0, 1, "R3 held s4");
    cyc(1, 1, 0, 1, 0, 0, 8'h00, 0, 1, "R3 held s5");
    cyc(0, 0, 1, 1, 0, 0, 8'h00, 0, 1, "R3 held at update");
    // R7 delay
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 0, "R7 delay c1");
    cyc(0, 0, 0, 1, 0, 0, 8'h00, 0, 1, "R7 delay c2");
    cyc(0, 0, 0, 1, 0, 0, 8'h00, 0, 0, "R7 delay c3");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 0, "R7 delay c4");
    cyc(0, 0, 0, 1, 0, 0, 8'h00, 0, 1, "R7 delay c5");

    // R8 SEU in phase0
    load(6'b000_100);
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 0, "R8 pulse after update");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 1, "R8 no repeat 1");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 1, "R8 no repeat 2");
    cyc(0, 0, 0, 1, 1, 1, 8'h00, 0, 1, "R8 other phase none");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 0, "R8 pulse on phase entry");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 1, "R8 single after phase");
    cyc(0, 0, 0, 0, 0, 1, 8'h00, 0, 1, "R8 disabled");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 0, "R8 pulse on enable rise");
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 1, "R8 single after enable");

    // R9 stuck-open, mask bits 0 and 2
    load(6'b000_101);
    cyc(0, 0, 0, 1, 0, 0, 8'hFF, 0, 1, "R9 all ones");
    cyc(0, 0, 0, 1, 0, 0, 8'h05, 0, 1, "R9 masked ones");
    cyc(0, 0, 0, 1, 0, 1, 8'h04, 0, 0, "R9 bit0 low");
    cyc(0, 0, 0, 1, 0, 1, 8'hFA, 0, 0, "R9 masked low");
    cyc(0, 0, 0, 1, 0, 1, 8'h01, 0, 0, "R9 bit2 low");

    // R10 unused codes
    load(6'b111_110);
    cyc(0, 0, 0, 1, 0, 1, 8'h00, 0, 1, "R10 code6 hi");
    cyc(0, 0, 0, 1, 0, 0, 8'h00, 0, 0, "R10 code6 lo");
    cyc(0, 0, 0, 1, 1, 1, 8'h00, 0, 1, "R10 code7 hi");
    cyc(0, 0, 0, 1, 1, 0, 8'h00, 0, 0, "R10 code7 lo");

    // R11 update with shift takes pre-shift contents (000_010 = SA1)
    for (int i = 5; i >= 0; i--)
      cyc(1, (i == 1) ? 1'b1 : 1'b0, 0, 1, 0, 0, 8'h00, -1, 0, "");
    cyc(1, 1, 1, 1, 0, 0, 8'h00, -1, 0, "");
    cyc(0, 0, 0, 1, 0, 0, 8'h00, 0, 1, "R11 pre-shift pattern");

    // R1 reset mid-run clears pattern
    @(negedge clk); rst_ni = 1'b0;
    cyc(0, 0, 0, 1, 0, 0, 8'h00, 0, 0, "R1 out in second reset");
    push(1, 0, "R1 chain cleared");
    @(negedge clk); rst_ni = 1'b1;
    cyc(0, 0, 0, 1, 0, 0, 8'h00, 0, 0, "R1 no fault after reset");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule